// File: doc/BRIEF.md
# Configuration Image Header Locator

This block inspects a configuration image as it streams in, before any of it reaches the device being configured. Starting from a fixed byte position, it follows a chain of length-prefixed text fields and records where each field's length byte sits. In the same pass, it searches from byte zero for the synchronisation pattern that opens the configuration payload. It reports the byte offset of the first payload byte, or a not-found flag if the pattern never appears.

Software or a loader engine pulses `start_i` with the image size and the pattern variant. It then feeds bytes over a valid/ready handshake. The block accepts exactly `size_i` bytes and then raises one of two verdict flags. Both verdicts and all the offsets stay unchanged until the next start pulse.

Top module: `cfg_hdr_locator`

## Requirements
- R1: After reset, `byte_ready_o`, `busy_o`, `pay_vld_o`, `miss_o` and `field_vld_o` are all low, and `pay_off_o` is zero.
- R2: A start pulse latches `size_i` and `mode_i`. The block then holds `byte_ready_o` high until exactly `size_i` bytes have been accepted. In the cycle after the last accepted byte, `byte_ready_o` is low and either `pay_vld_o` or `miss_o` is high.
- R3: While the block is scanning, a start pulse is ignored. The size, mode and results of the scan in progress do not change.
- R4: The field walk starts at byte 15. The byte at the current walk position is a length L. Its position is reported as the next field's offset, and the walk moves to that position plus L plus 3. Four fields are walked. Field k is reported in `field_off_o[32k+31:32k]`, and bit k of `field_vld_o` is set.
- R5: A field whose walk position is at or beyond the image size is never reported. Its valid bit stays low and its offset stays zero. The same holds for every field after it.
- R6: With `mode_i`=0, the payload offset is the position of the first byte of the earliest run of four consecutive 0xFF bytes.
- R7: With `mode_i`=1, the payload offset is two more than the position of the earliest 0xFF byte whose following byte has upper nibble 0x3. A 0xFF in the last byte of the image never matches.
- R8: Only the earliest match counts. Later matches, including overlapping ones inside a longer 0xFF run, do not change `pay_off_o`.
- R9: If the image ends with no match, `miss_o` goes high, `pay_vld_o` stays low and `pay_off_o` is zero.
- R10: Once a verdict is shown, all outputs stay stable and no byte is accepted until the next start pulse. A start pulse clears the verdicts, `field_vld_o`, the field offsets and `pay_off_o`.
- R11: A start with `size_i`=0 accepts no byte and gives `miss_o` in the next cycle.
- R12: The sync search covers the whole image from byte 0, independent of the field walk. A pattern lying before byte 15, or inside field text, is found.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; latches size and mode |
| mode_i | input | 1 | Sync variant: 0 four 0xFF bytes, 1 0xFF then 0x3? |
| size_i | input | 32 | Image length in bytes |
| byte_data_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Byte present |
| byte_ready_o | output | 1 | Byte accepted when valid is also high |
| field_off_o | output | 128 | Four 32-bit field offsets, field k in bits 32k+31:32k |
| field_vld_o | output | 4 | Bit k set when field k was reached |
| pay_off_o | output | 32 | Offset of the first payload byte |
| pay_vld_o | output | 1 | Scan done, pattern found |
| miss_o | output | 1 | Scan done, pattern not found |
| busy_o | output | 1 | Scan in progress |

## Verification
The assertions take for granted that the image size fits the offset width, so that a field jump of length plus 3 never wraps. They also assume that the walk positions increase strictly. The stimulus keeps images under 512 bytes, which holds both assumptions.

Start pulses are kept clear of the accepting state, except in the one case that deliberately tests the ignored start. Valid gaps are inserted at random so that the handshake, not the clock, paces the search. The random bytes are weighted toward 0xFF and 0x3? values so that both patterns, overlapping runs and late matches occur often.

// File: rtl/cil_pkg.sv
package cil_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } cil_state_e;

  typedef enum logic {
    SYNC_QUAD_FF = 1'b0,
    SYNC_FF_NIB3 = 1'b1
  } sync_mode_e;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [3:0] SYNC_NIB  = 4'h3;
  localparam int         WIN_LEN   = 3;
endpackage

// File: rtl/cil_seq.sv
module cil_seq
  import cil_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [OFF_W-1:0] size_i,
  input  logic             byte_valid_i,
  output logic             ready_o,
  output logic             acc_o,
  output logic             clr_o,
  output logic             fin_o,
  output logic [OFF_W-1:0] idx_o,
  output sync_mode_e       mode_o
);
  cil_state_e       state_q;
  logic [OFF_W-1:0] size_q;
  logic [OFF_W-1:0] idx_q;
  sync_mode_e       mode_q;
  logic             start_ok;
  logic             last_byte;

  assign start_ok  = start_i && (state_q != ST_SCAN);
  assign ready_o   = (state_q == ST_SCAN);
  assign acc_o     = ready_o && byte_valid_i;
  assign last_byte = (idx_q == size_q - OFF_W'(1));
  assign clr_o     = start_ok;
  assign fin_o     = (state_q == ST_DONE);
  assign idx_o     = idx_q;
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      size_q  <= '0;
      idx_q   <= '0;
      mode_q  <= SYNC_QUAD_FF;
    end else if (start_ok) begin
      size_q  <= size_i;
      mode_q  <= sync_mode_e'(mode_i);
      idx_q   <= '0;
      state_q <= (size_i == '0) ? ST_DONE : ST_SCAN;
    end else if (acc_o) begin
      idx_q <= idx_q + OFF_W'(1);
      if (last_byte) state_q <= ST_DONE;
    end
  end

  // R2
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN) |-> (idx_q < size_q));

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && start_i) |=> ($stable(size_q) && $stable(mode_q)));

  // R11
  empty_image_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_SCAN && size_i == '0) |=> (fin_o && !ready_o));
endmodule

// File: rtl/cil_field_walk.sv
module cil_field_walk #(
  parameter int N_FIELDS  = 4,
  parameter int OFF_W     = 32,
  parameter int FIRST_OFF = 15,
  parameter int FIELD_GAP = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      acc_i,
  input  logic [OFF_W-1:0]          idx_i,
  input  logic [7:0]                data_i,
  output logic [N_FIELDS*OFF_W-1:0] field_off_o,
  output logic [N_FIELDS-1:0]       field_vld_o
);
  localparam int CNT_W = $clog2(N_FIELDS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] next_q;
  logic             walk_hit;

  assign walk_hit = acc_i && (cnt_q < CNT_W'(N_FIELDS)) && (idx_i == next_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      next_q <= OFF_W'(FIRST_OFF);
    end else if (clr_i) begin
      cnt_q  <= '0;
      next_q <= OFF_W'(FIRST_OFF);
    end else if (walk_hit) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      next_q <= idx_i + OFF_W'(data_i) + OFF_W'(FIELD_GAP);
    end
  end

  for (genvar k = 0; k < N_FIELDS; k++) begin : g_field
    logic [OFF_W-1:0] off_q;
    logic             vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        off_q <= '0;
        vld_q <= 1'b0;
      end else if (clr_i) begin
        off_q <= '0;
        vld_q <= 1'b0;
      end else if (walk_hit && cnt_q == CNT_W'(k)) begin
        off_q <= idx_i;
        vld_q <= 1'b1;
      end
    end

    assign field_off_o[k*OFF_W +: OFF_W] = off_q;
    assign field_vld_o[k]                = vld_q;

    if (k > 0) begin : g_order
      // R5
      field_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_q |-> g_field[k-1].vld_q);
    end
  end

  // R4
  field_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_FIELDS));

  // R4
  walk_forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_hit && !clr_i) |=> (next_q > $past(idx_i)));
endmodule

// File: rtl/cil_sync_det.sv
module cil_sync_det
  import cil_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [OFF_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  sync_mode_e       mode_i,
  output logic             found_o,
  output logic [OFF_W-1:0] off_o
);
  logic [7:0]       win_q [WIN_LEN];
  logic             found_q;
  logic [OFF_W-1:0] off_q;
  logic             hit_quad;
  logic             hit_nib;
  logic             hit;
  logic [OFF_W-1:0] hit_off;

  always_comb begin
    hit_quad = (idx_i >= OFF_W'(WIN_LEN)) && (data_i == SYNC_BYTE);
    for (int i = 0; i < WIN_LEN; i++) begin
      hit_quad = hit_quad && (win_q[i] == SYNC_BYTE);
    end
  end

  // Pattern sits one byte back; payload two past the 0xFF.
  assign hit_nib = (idx_i != '0) && (win_q[0] == SYNC_BYTE) && (data_i[7:4] == SYNC_NIB);

  always_comb begin
    unique case (mode_i)
      SYNC_QUAD_FF: begin
        hit     = hit_quad;
        hit_off = idx_i - OFF_W'(WIN_LEN);
      end
      default: begin
        hit     = hit_nib;
        hit_off = idx_i + OFF_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WIN_LEN; i++) win_q[i] <= '0;
      found_q <= 1'b0;
      off_q   <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < WIN_LEN; i++) win_q[i] <= '0;
      found_q <= 1'b0;
      off_q   <= '0;
    end else if (acc_i) begin
      win_q[0] <= data_i;
      for (int i = 1; i < WIN_LEN; i++) win_q[i] <= win_q[i-1];
      if (!found_q && hit) begin
        found_q <= 1'b1;
        off_q   <= hit_off;
      end
    end
  end

  assign found_o = found_q;
  assign off_o   = off_q;

  // R8
  first_match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_q && !clr_i) |=> (found_q && $stable(off_q)));

  // R6
  match_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_q) |-> $past(acc_i));

  // R9
  idle_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_q |-> (off_q == '0));
endmodule

// File: rtl/cfg_hdr_locator.sv
module cfg_hdr_locator
  import cil_pkg::*;
#(
  parameter int N_FIELDS  = 4,
  parameter int OFF_W     = 32,
  parameter int FIRST_OFF = 15,
  parameter int FIELD_GAP = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      mode_i,
  input  logic [OFF_W-1:0]          size_i,
  input  logic [7:0]                byte_data_i,
  input  logic                      byte_valid_i,
  output logic                      byte_ready_o,
  output logic [N_FIELDS*OFF_W-1:0] field_off_o,
  output logic [N_FIELDS-1:0]       field_vld_o,
  output logic [OFF_W-1:0]          pay_off_o,
  output logic                      pay_vld_o,
  output logic                      miss_o,
  output logic                      busy_o
);
  logic             acc;
  logic             clr;
  logic             fin;
  logic [OFF_W-1:0] idx;
  sync_mode_e       mode;
  logic             found;

  cil_seq #(.OFF_W(OFF_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .size_i       (size_i),
    .byte_valid_i (byte_valid_i),
    .ready_o      (byte_ready_o),
    .acc_o        (acc),
    .clr_o        (clr),
    .fin_o        (fin),
    .idx_o        (idx),
    .mode_o       (mode)
  );

  cil_field_walk #(
    .N_FIELDS  (N_FIELDS),
    .OFF_W     (OFF_W),
    .FIRST_OFF (FIRST_OFF),
    .FIELD_GAP (FIELD_GAP)
  ) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .acc_i       (acc),
    .idx_i       (idx),
    .data_i      (byte_data_i),
    .field_off_o (field_off_o),
    .field_vld_o (field_vld_o)
  );

  cil_sync_det #(.OFF_W(OFF_W)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .acc_i   (acc),
    .idx_i   (idx),
    .data_i  (byte_data_i),
    .mode_i  (mode),
    .found_o (found),
    .off_o   (pay_off_o)
  );

  assign pay_vld_o = fin && found;
  assign miss_o    = fin && !found;
  assign busy_o    = byte_ready_o;

  // R10
  verdict_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_vld_o && !start_i) |=> (pay_vld_o && $stable(pay_off_o) && $stable(field_off_o)));

  // R10
  no_take_after_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pay_vld_o || miss_o) |-> !byte_ready_o);
endmodule

// File: tb/cfg_hdr_locator_tb.sv
module cfg_hdr_locator_tb;
  localparam int NF = 4;
  localparam int OW = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mode = 1'b0;
  logic [OW-1:0]    size = '0;
  logic [7:0]       bdata = '0;
  logic             bvalid = 1'b0;
  logic             bready;
  logic [NF*OW-1:0] foff;
  logic [NF-1:0]    fvld;
  logic [OW-1:0]    poff;
  logic             pvld;
  logic             miss;
  logic             busy;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  logic [7:0] img [0:511];
  int  e_found;
  int  e_off;
  int  e_fvld [NF];
  int  e_foff [NF];

  always #2 clk = ~clk;

  cfg_hdr_locator u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .mode_i       (mode),
    .size_i       (size),
    .byte_data_i  (bdata),
    .byte_valid_i (bvalid),
    .byte_ready_o (bready),
    .field_off_o  (foff),
    .field_vld_o  (fvld),
    .pay_off_o    (poff),
    .pay_vld_o    (pvld),
    .miss_o       (miss),
    .busy_o       (busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic model(input int sz, input bit md);
    int pos;
    e_found = 0;
    e_off   = 0;
    pos     = 15;
    for (int k = 0; k < NF; k++) begin
      e_fvld[k] = 0;
      e_foff[k] = 0;
      if (pos < sz) begin
        e_fvld[k] = 1;
        e_foff[k] = pos;
        pos = pos + int'(img[pos]) + 3;
      end else begin
        pos = 1 << 30;
      end
    end
    for (int p = 0; p < sz && !e_found; p++) begin
      if (!md && p + 3 < sz && img[p] == 8'hFF && img[p+1] == 8'hFF &&
          img[p+2] == 8'hFF && img[p+3] == 8'hFF) begin
        e_found = 1;
        e_off   = p;
      end else if (md && p + 1 < sz && img[p] == 8'hFF && img[p+1][7:4] == 4'h3) begin
        e_found = 1;
        e_off   = p + 2;
      end
    end
  endtask

  task automatic check_result(input string tag);
    chk(pvld == e_found[0], {tag, " R6/R7 pay_vld"}, pvld, e_found);
    chk(miss == !e_found[0], {tag, " R9 miss"}, miss, !e_found);
    chk(poff == e_off, {tag, " R6 R7 R8 R12 pay_off"}, poff, e_off);
    chk(!bready, {tag, " R2 ready low after image"}, bready, 0);
    for (int k = 0; k < NF; k++) begin
      chk(fvld[k] == e_fvld[k][0], {tag, " R4 R5 field_vld"}, fvld[k], e_fvld[k]);
      chk(foff[k*OW +: OW] == e_foff[k], {tag, " R4 R5 field_off"}, foff[k*OW +: OW], e_foff[k]);
    end
  endtask

  task automatic run_image(input int sz, input bit md, input int inject, input bit gaps, input string tag);
    model(sz, md);
    @(negedge clk);
    start = 1'b1; size = sz; mode = md;
    @(negedge clk);
    start = 1'b0;
    chk(pvld == 0 && fvld == 0 && poff == 0, {tag, " R10 start clears"}, {pvld, fvld}, 0);
    for (int i = 0; i < sz; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        bvalid = 1'b0;
        @(negedge clk);
      end
      chk(bready, {tag, " R2 ready during scan"}, bready, 1);
      if (i == inject) begin
        start = 1'b1; size = 3; mode = !md;
      end
      bvalid = 1'b1;
      bdata  = img[i];
      @(posedge clk);
      @(negedge clk);
      start  = 1'b0;
      bvalid = 1'b0;
    end
    check_result(tag);
  endtask

  task automatic clear_img();
    for (int i = 0; i < 512; i++) img[i] = 8'h00;
  endtask

  task automatic std_header();
    img[15] = 8'd2;
    img[20] = 8'd1;
    img[24] = 8'd0;
    img[27] = 8'd5;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk(!bready && !busy && !pvld && !miss && fvld == 0 && poff == 0, "R1 reset state",
        {bready, busy, pvld, miss, fvld}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R6 quad pattern after header
    clear_img(); std_header();
    for (int i = 40; i < 44; i++) img[i] = 8'hFF;
    run_image(60, 1'b0, -1, 1'b0, "quad_hdr");

    // R7 nibble pattern after header
    clear_img(); std_header();
    img[40] = 8'hFF; img[41] = 8'h3A;
    run_image(60, 1'b1, -1, 1'b1, "nib_hdr");

    // R12 R5 pattern before byte 15 and long first field
    clear_img();
    for (int i = 2; i < 6; i++) img[i] = 8'hFF;
    img[15] = 8'hFF;
    run_image(60, 1'b0, -1, 1'b0, "early_sync");

    // R7 0xFF in last byte never matches
    clear_img();
    img[9] = 8'hFF;
    run_image(10, 1'b1, -1, 1'b0, "nib_last");

    // R7 pattern ending at last byte gives offset equal to size
    clear_img();
    img[8] = 8'hFF; img[9] = 8'h31;
    run_image(10, 1'b1, -1, 1'b0, "nib_tail");

    // R8 longer 0xFF run
    clear_img();
    for (int i = 30; i < 35; i++) img[i] = 8'hFF;
    img[50] = 8'hFF; img[51] = 8'hFF; img[52] = 8'hFF; img[53] = 8'hFF;
    run_image(60, 1'b0, -1, 1'b0, "quad_run");

    // R8 nibble after repeated 0xFF
    clear_img();
    img[30] = 8'hFF; img[31] = 8'hFF; img[32] = 8'h31;
    img[40] = 8'hFF; img[41] = 8'h30;
    run_image(60, 1'b1, -1, 1'b0, "nib_run");

    // R9 no match
    clear_img();
    img[3] = 8'hFF; img[4] = 8'hFF; img[5] = 8'hFF;
    run_image(20, 1'b0, -1, 1'b0, "no_match");

    // R10 verdict holds and extra bytes are refused
    bvalid = 1'b1; bdata = 8'hFF;
    repeat (5) @(negedge clk);
    bvalid = 1'b0;
    check_result("hold");

    // R11 empty image
    @(negedge clk);
    start = 1'b1; size = 0; mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(miss && !pvld && !bready, "R11 empty image", {miss, pvld, bready}, 3'b100);

    // R3 start ignored mid-scan
    clear_img(); std_header();
    img[45] = 8'hFF; img[46] = 8'h3F;
    run_image(60, 1'b1, 10, 1'b1, "start_mid_scan R3");

    // random images
    for (int n = 0; n < 60; n++) begin
      int sz;
      bit md;
      sz = 8 + int'($urandom % 300);
      md = $urandom % 2;
      for (int i = 0; i < sz; i++) begin
        case ($urandom % 8)
          0, 1, 2: img[i] = 8'hFF;
          3:       img[i] = {4'h3, 4'($urandom)};
          default: img[i] = 8'($urandom % 24);
        endcase
      end
      run_image(sz, md, -1, 1'b1, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule